// File: doc/BRIEF.md
# Electronic Shutter Integration Controller

This block sets how long an image sensor integrates charge. While integration has not yet begun, it drives an active-low charge-sweep pulse that empties the photodiodes. The start of integration is set by three fields. The coarse field counts whole fields. The mid field counts horizontal lines. The fine field counts steps of `STEP_CLKS` clocks inside a line. The block follows the line strobe `hd` and the field strobe `vd`. It also raises a flag, `sweep_active`, that a blanking generator can use to mask lines that are being swept.

The integration period can span several fields. In that case, sweeping happens in one field out of every `field_cnt + 1`. The fields in between are skip fields with no sweep at all. When `shutter_en` is low, the sweep output is held high and the flag is held low.

The controller is a five-state machine:
- `SH_OFF`: shutter disabled.
- `SH_SWEEP`: sweep pulses are being issued.
- `SH_FINAL`: the last pulse is in progress.
- `SH_HOLD`: integrating, no further pulses this field.
- `SH_SKIP`: field with no sweep.

Transitions:
- Any state goes to `SH_OFF` when `shutter_en` is low.
- On `vd`, the state goes to `SH_SWEEP` when the field phase wraps to 0, and to `SH_SKIP` otherwise.
- `SH_SWEEP` goes to `SH_FINAL` when the last pulse is issued.
- `SH_FINAL` goes to `SH_HOLD` when that pulse ends.
- `SH_OFF` leaves only on a `vd` with `shutter_en` high.

Top module: `shutter_ctrl`

## Requirements
- R1: After reset, `sweep_n` is 1 and `sweep_active` is 0, and both stay so until a `vd` is sampled with `shutter_en` high.
- R2: In the cycle after any edge that samples `shutter_en` low, `sweep_n` is 1 and `sweep_active` is 0. The next `vd` sampled with `shutter_en` high starts a sweep field.
- R3: Field phase and sweep fields:
  - Each `vd` sampled with `shutter_en` high advances a field phase. The phase wraps to 0 once it has reached `field_cnt`.
  - A field whose phase is 0 is a sweep field. So with `field_cnt` = N, one field in N+1 sweeps.
- R4: A skip field (phase not 0) produces no sweep pulse, and `sweep_active` is 0 throughout it.
- R5: Line timing and ordinary sweep pulses:
  - An edge that samples `vd` starts line 0.
  - An edge that samples `hd` without `vd` starts the next line.
  - In a sweep field, each line with index below `line_cnt` gets one pulse. `sweep_n` goes low two edges after the line-start edge and stays low for `PULSE_LEN` cycles.
- R6: Final pulse:
  - The final pulse is in line `line_cnt`. It begins `step_cnt*STEP_CLKS` cycles later than an ordinary pulse would in that line.
  - A sweep field whose lines are long enough therefore holds exactly `line_cnt + 1` pulses.
- R7: `sweep_active` is 1 from the cycle after the `vd` edge that opens a sweep field through the last low cycle of the final pulse. It is 0 from then until the next `vd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd | input | 1 | One-cycle line start strobe |
| vd | input | 1 | One-cycle field start strobe, also starts line 0 |
| shutter_en | input | 1 | 1 = electronic shutter operation, 0 = sweep held idle |
| field_cnt | input | FIELD_W | Whole-field part of integration time |
| line_cnt | input | LINE_W | Line part of integration time |
| step_cnt | input | STEP_W | Sub-line part, in units of STEP_CLKS clocks |
| sweep_n | output | 1 | Active-low charge-sweep pulse |
| sweep_active | output | 1 | High while the current field is still being swept |

## Verification
The hardest state to reach is the field-phase counter wrapping under a nonzero `field_cnt`. Another is a disable that arrives in the middle of a pulse, followed by the first field after re-enabling. The bench runs whole fields of six 400-clock lines. It switches `field_cnt` to 2 and then 3 so that skip fields and wraps occur. It drops `shutter_en` three cycles into the first pulse of a field and re-enables it before a later `vd`. A behavioural reference model tracks line position, phase and the remaining low cycles, and is compared with both outputs on every clock. Per-field pulse counts confirm the `line_cnt + 1` total and the silent skip fields.

// File: rtl/shutter_pkg.sv
package shutter_pkg;

    typedef enum logic [2:0] {
        SH_OFF   = 3'd0,
        SH_SWEEP = 3'd1,
        SH_FINAL = 3'd2,
        SH_HOLD  = 3'd3,
        SH_SKIP  = 3'd4
    } sh_state_t;

endpackage

// File: rtl/shutter_timebase.sv
module shutter_timebase #(
    parameter int PX_W = 13,
    parameter int LN_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hd,
    input  logic            vd,
    output logic [PX_W-1:0] px,
    output logic [LN_W-1:0] ln
);

    // Position counters: clocks since line start, lines since field start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            px <= '0;
            ln <= '0;
        end else if (vd) begin
            px <= '0;
            ln <= '0;
        end else if (hd) begin
            px <= '0;
            if (ln != '1) ln <= ln + 1'b1;
        end else if (px != '1) begin
            px <= px + 1'b1;
        end
    end

endmodule

// File: rtl/shutter_pulse.sv
module shutter_pulse #(
    parameter int PULSE_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_hi,
    input  logic fire,
    output logic sweep_n,
    output logic done
);

    localparam int REM_W = $clog2(PULSE_LEN + 1);

    logic [REM_W-1:0] rem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem     <= '0;
            sweep_n <= 1'b1;
        end else if (force_hi) begin
            rem     <= '0;
            sweep_n <= 1'b1;
        end else if (fire) begin
            rem     <= REM_W'(PULSE_LEN - 1);
            sweep_n <= 1'b0;
        end else if (rem != '0) begin
            rem     <= rem - 1'b1;
            sweep_n <= 1'b0;
        end else begin
            sweep_n <= 1'b1;
        end
    end

    assign done = (rem == '0);

    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        force_hi |=> sweep_n); // R2

endmodule

// File: rtl/shutter_ctrl.sv
module shutter_ctrl
    import shutter_pkg::*;
#(
    parameter int FIELD_W   = 3,
    parameter int LINE_W    = 9,
    parameter int STEP_W    = 6,
    parameter int STEP_CLKS = 112,
    parameter int PULSE_LEN = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hd,
    input  logic               vd,
    input  logic               shutter_en,
    input  logic [FIELD_W-1:0] field_cnt,
    input  logic [LINE_W-1:0]  line_cnt,
    input  logic [STEP_W-1:0]  step_cnt,
    output logic               sweep_n,
    output logic               sweep_active
);

    localparam int PX_W = $clog2((2 ** STEP_W) * STEP_CLKS + 1);
    localparam int LN_W = LINE_W + 1;

    sh_state_t         state, state_nx;
    logic [FIELD_W-1:0] phase, phase_nx;
    logic [PX_W-1:0]   px;
    logic [LN_W-1:0]   ln;
    logic [PX_W-1:0]   tgt;
    logic              fire, fire_mid, fire_last, pulse_done, quiet;

    shutter_timebase #(.PX_W(PX_W), .LN_W(LN_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .hd(hd), .vd(vd), .px(px), .ln(ln)
    );

    shutter_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .force_hi(!shutter_en), .fire(fire),
        .sweep_n(sweep_n), .done(pulse_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SH_OFF;
            phase <= '1;
        end else begin
            state <= state_nx;
            phase <= phase_nx;
        end
    end

    // Next state and outputs
    always_comb begin
        tgt       = PX_W'(step_cnt) * PX_W'(STEP_CLKS);
        quiet     = !vd && !hd && (state == SH_SWEEP);
        fire_mid  = quiet && (ln < LN_W'(line_cnt)) && (px == '0);
        fire_last = quiet && (ln == LN_W'(line_cnt)) && (px == tgt);
        fire      = fire_mid || fire_last;
        sweep_active = (state == SH_SWEEP) || (state == SH_FINAL);
        state_nx  = state;
        phase_nx  = phase;
        if (!shutter_en) begin
            state_nx = SH_OFF;
            phase_nx = '1;
        end else if (vd) begin
            phase_nx = (phase >= field_cnt) ? '0 : phase + 1'b1;
            state_nx = (phase_nx == '0) ? SH_SWEEP : SH_SKIP;
        end else begin
            unique case (state)
                SH_OFF:   state_nx = SH_OFF;
                SH_SWEEP: if (fire_last) state_nx = SH_FINAL;
                SH_FINAL: if (pulse_done) state_nx = SH_HOLD;
                SH_HOLD:  state_nx = SH_HOLD;
                SH_SKIP:  state_nx = SH_SKIP;
                default:  state_nx = SH_OFF;
            endcase
        end
    end

    AST_ACTIVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !shutter_en |=> !sweep_active); // R2

    AST_FALL_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sweep_n) |-> ($past(state) == SH_SWEEP)); // R5

    AST_RISE_AT_VD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sweep_active) |-> $past(vd)); // R3

    AST_FINAL_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sweep_active) && ($past(state) == SH_FINAL) && $past(shutter_en) && !$past(vd))
        |-> $rose(sweep_n)); // R7

    AST_SKIP_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SH_SKIP) |-> !fire); // R4

endmodule

// File: tb/sim_shutter_ctrl.sv
module sim_shutter_ctrl;

    localparam int LINE   = 400;
    localparam int NLINES = 6;
    localparam int PLEN   = 8;
    localparam int STEP   = 112;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       hd = 1'b0, vd = 1'b0, en = 1'b0;
    logic [2:0] fc = '0;
    logic [8:0] lc = '0;
    logic [5:0] sc = '0;
    logic       sweep_n, sweep_active;

    shutter_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .hd(hd), .vd(vd), .shutter_en(en),
        .field_cnt(fc), .line_cnt(lc), .step_cnt(sc),
        .sweep_n(sweep_n), .sweep_active(sweep_active)
    );

    int n_cmp = 0, n_bad = 0, falls = 0;
    bit finished = 1'b0;
    logic prev_sn = 1'b1;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_px = 0, m_ln = 0, m_mode = 0, m_phase = 7, m_low = 0;
    int olow, np;
    bit fm, fl;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_px = 0; m_ln = 0; m_mode = 0; m_phase = 7; m_low = 0;
        end else begin
            olow = m_low;
            fm = (m_mode == 1) && !vd && !hd && (m_ln < int'(lc)) && (m_px == 0);
            fl = (m_mode == 1) && !vd && !hd && (m_ln == int'(lc)) && (m_px == int'(sc) * STEP);
            if (!en) m_low = 0;
            else if (fm || fl) m_low = PLEN;
            else if (m_low > 0) m_low--;
            if (!en) begin
                m_mode = 0; m_phase = 7;
            end else if (vd) begin
                np = (m_phase >= int'(fc)) ? 0 : m_phase + 1;
                m_phase = np;
                m_mode = (np == 0) ? 1 : 4;
            end else if (m_mode == 1 && fl) m_mode = 2;
            else if (m_mode == 2 && olow == 1) m_mode = 3;
            if (vd) begin m_px = 0; m_ln = 0; end
            else if (hd) begin m_px = 0; m_ln++; end
            else m_px++;
        end
    end

    // Every-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R5 sweep_n", int'(sweep_n), (m_low > 0) ? 0 : 1);
            chk("R7 sweep_active", int'(sweep_active), (m_mode == 1 || m_mode == 2) ? 1 : 0);
        end
        if (prev_sn && !sweep_n) falls++;
        prev_sn = sweep_n;
    end

    task automatic run_field();
        for (int l = 0; l < NLINES; l++) begin
            @(negedge clk);
            if (l == 0) vd = 1'b1; else hd = 1'b1;
            @(negedge clk);
            vd = 1'b0; hd = 1'b0;
            repeat (LINE - 2) @(negedge clk);
        end
    endtask

    task automatic field_count(input string req, input int exp);
        int f0;
        f0 = falls;
        run_field();
        chk(req, falls - f0, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 reset sweep_n", int'(sweep_n), 1);
        chk("R1 reset sweep_active", int'(sweep_active), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle sweep_n", int'(sweep_n), 1);

        // Every field sweeps with a zero field count
        en = 1'b1; fc = 3'd0; lc = 9'd2; sc = 6'd1;
        field_count("R6 pulses lc=2", 3);
        field_count("R3 next field sweeps", 3);
        lc = 9'd4; sc = 6'd3;
        field_count("R6 pulses lc=4 step=3", 5);
        lc = 9'd0; sc = 6'd0;
        field_count("R6 single pulse lc=0", 1);

        // Multi-field integration: phase 0 -> 1,2 skip, then sweep
        fc = 3'd2; lc = 9'd1; sc = 6'd2;
        field_count("R4 skip field 1", 0);
        field_count("R4 skip field 2", 0);
        field_count("R3 sweep after wrap", 2);
        field_count("R4 skip field 3", 0);
        field_count("R4 skip field 4", 0);
        field_count("R3 sweep second wrap", 2);

        // Disable in the middle of the first pulse
        fc = 3'd0; lc = 9'd2; sc = 6'd0;
        @(negedge clk); vd = 1'b1;
        @(negedge clk); vd = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 pulse low before disable", int'(sweep_n), 0);
        en = 1'b0;
        @(negedge clk);
        chk("R2 disable forces high", int'(sweep_n), 1);
        chk("R2 disable clears flag", int'(sweep_active), 0);
        begin
            int f0;
            f0 = falls;
            for (int l = 1; l < NLINES; l++) begin
                @(negedge clk); hd = 1'b1;
                @(negedge clk); hd = 1'b0;
                repeat (LINE - 2) @(negedge clk);
            end
            chk("R2 no pulses while disabled", falls - f0, 0);
        end
        fc = 3'd3; lc = 9'd1;
        en = 1'b1;
        field_count("R3 first field after enable sweeps", 2);
        field_count("R4 skip after enable", 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule